// File: doc/BRIEF.md
# Capture/Compare Timer Event Counter

This block is a W-bit up-counter (16 bits by default) with two channel registers and a small control word. The counter advances on a count-enable tick from a prescaler outside the block, or on a selected edge of an external event pin. A two-bit mode field chooses one of four behaviours: stopped, free-running, clear-and-start when the count matches channel 0, or clear-and-start on a valid edge of the event pin. A sticky overflow flag records each wrap of the counter from all ones to zero.

Each channel register acts either as a compare register or as a capture register. In compare mode it raises a one-cycle interrupt pulse when the counter leaves the compared value. In capture mode it latches the count on a rising edge of the capture pin and also pulses its interrupt. Both pins pass through a two-flop synchronizer and an edge detector, so a pin edge takes effect on the third rising clock edge after the pin changes. Software accesses the block through a simple write port and a combinational read port.

Top module: `cc_timer`

## Requirements
- R1: Control bits [1:0] select the mode: 00 stopped, 01 free-running, 10 clear on channel-0 match, 11 clear on event-pin edge. A non-zero mode starts counting on the next tick. Writing 00 stops the counter and holds the count at zero.
- R2: While the counter is stopped, the count stays at zero and no interrupt pulses. Channel registers in capture mode ignore capture-pin edges.
- R3: In every counting mode, a tick that moves the count from all ones to zero sets the overflow flag (control bit 8). In match-clear mode this happens only when channel 0 holds all ones.
- R4: A write to the control word with bit 8 at 0 clears the overflow flag. In the window after a wrap and before the next counting tick, that clear has no effect. A write with bit 8 at 1 leaves the flag unchanged.
- R5: A channel in compare mode pulses its interrupt for one cycle when a counting tick advances the counter from a value equal to its register. A compare value of zero therefore fires when the count steps from 0 to 1 after a wrap.
- R6: In match-clear mode, a tick taken while the count equals channel 0 reloads the count to zero and pulses the channel-0 interrupt. This reload does not set the overflow flag unless the count was all ones.
- R7: A compare value written below the current count does not stop or reset counting. The match occurs only on the next pass, after the wrap.
- R8: Control bit 4 puts channel 0, and bit 5 puts channel 1, in capture mode. There, a rising edge on cap_pin copies the count into the register and pulses the channel interrupt. If a bus read or write of the same register falls in that cycle, the capture wins and the write is dropped.
- R9: A channel in compare mode ignores capture-pin edges. Its register and interrupt are unaffected.
- R10: Control bits [3:2] select the valid event-pin edge: 00 rising, 01 falling, 1x both. Writes to this field are accepted only while the mode is stopped; while running, the field keeps its old value.
- R11: In pin-edge-clear mode, a valid edge on evt_pin returns the count to zero. An edge of the other polarity has no effect.
- R12: Control bit 6 set makes valid evt_pin edges, instead of tick, the counting clock.
- R13: Registers sit at address 0 (channel 0), address 1 (channel 1) and address 2 (control). After reset, every register, the count, the flag and the interrupts are zero. rd_data is zero when rd_en is low or the address is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| tick | input | 1 | Count-enable pulse from the external prescaler |
| evt_pin | input | 1 | External event pin, asynchronous |
| cap_pin | input | 1 | External capture trigger pin, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Read address |
| rd_data | output | W | Read data, combinational |
| irq_ch | output | 2 | Per-channel match/capture interrupt pulses |
| ovf_flag | output | 1 | Sticky overflow flag |
| count | output | W | Current counter value |

## Verification
A corrupted count shows up on the count port one cycle after the faulty tick, and again at the next compare pulse, which then appears a pass early or late. A wrong wrap-window bit shows up as an overflow flag that clears when it must hold, or holds when it must clear, on the cycle after the control write. A capture or edge-select state that is wrong shows up on rd_data and irq_ch three clock edges after the pin edge.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;
   typedef enum logic [1:0] {
      MODE_STOP = 2'b00,
      MODE_FREE = 2'b01,
      MODE_MCLR = 2'b10,
      MODE_PCLR = 2'b11
   } tmr_mode_e;

   localparam logic [1:0] ADDR_CH0  = 2'd0;
   localparam logic [1:0] ADDR_CH1  = 2'd1;
   localparam logic [1:0] ADDR_CTRL = 2'd2;

   localparam int CTL_EDGE = 2;
   localparam int CTL_CAP0 = 4;
   localparam int CTL_SRC  = 6;
   localparam int CTL_OVF  = 8;
   localparam int CTL_BITS = 9;
endpackage

// File: rtl/cc_sync_edge.sv
module cc_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_i,
   input  logic [1:0] sel_i,
   output logic       hit_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cc_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh_q;
   logic              prev_q;
   logic              rise, fall;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q   <= '0;
         prev_q <= 1'b0;
      end else begin
         sh_q   <= {sh_q[STAGES-2:0], pin_i};
         prev_q <= sh_q[STAGES-1];
      end
   end

   assign rise = sh_q[STAGES-1] & ~prev_q;
   assign fall = ~sh_q[STAGES-1] & prev_q;

   always_comb begin
      case (sel_i)
         2'b00:   hit_o = rise;
         2'b01:   hit_o = fall;
         default: hit_o = rise | fall;
      endcase
   end
endmodule

// File: rtl/cc_count_core.sv
module cc_count_core
   import cc_timer_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  tmr_mode_e    mode_i,
   input  logic         cnt_en_i,
   input  logic         pin_clr_i,
   input  logic [W-1:0] cmp0_i,
   input  logic         ovf_clr_i,
   output logic         step_o,
   output logic [W-1:0] count_o,
   output logic         ovf_o,
   output logic         wrap_pend_o
);
   logic run, pclr, at_top, reload;

   assign run    = (mode_i != MODE_STOP);
   assign pclr   = (mode_i == MODE_PCLR) && pin_clr_i;
   assign step_o = run && cnt_en_i && !pclr;
   assign at_top = (count_o == {W{1'b1}});
   assign reload = (mode_i == MODE_MCLR) && (count_o == cmp0_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_o     <= '0;
         wrap_pend_o <= 1'b0;
      end else if (!run) begin
         count_o     <= '0;
         wrap_pend_o <= 1'b0;
      end else if (pclr) begin
         count_o     <= '0;
      end else if (step_o) begin
         count_o     <= reload ? '0 : count_o + W'(1);
         wrap_pend_o <= at_top;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ovf_o <= 1'b0;
      else if (step_o && at_top)
         ovf_o <= 1'b1;
      else if (ovf_clr_i && !wrap_pend_o)
         ovf_o <= 1'b0;
   end
endmodule

// File: rtl/cc_ccr_chan.sv
module cc_ccr_chan #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run_i,
   input  logic         cap_mode_i,
   input  logic         cap_trig_i,
   input  logic         step_i,
   input  logic [W-1:0] count_i,
   input  logic         wr_i,
   input  logic [W-1:0] wr_data_i,
   output logic [W-1:0] val_o,
   output logic         irq_o
);
   logic cap_hit, cmp_hit;

   assign cap_hit = run_i && cap_mode_i && cap_trig_i;
   assign cmp_hit = !cap_mode_i && step_i && (count_i == val_o);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val_o <= '0;
         irq_o <= 1'b0;
      end else begin
         irq_o <= cap_hit || cmp_hit;
         if (cap_hit)
            val_o <= count_i;
         else if (wr_i)
            val_o <= wr_data_i;
      end
   end
endmodule

// File: rtl/cc_timer.sv
module cc_timer
   import cc_timer_pkg::*;
#(
   parameter int W           = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         evt_pin,
   input  logic         cap_pin,
   input  logic         wr_en,
   input  logic [1:0]   wr_addr,
   input  logic [W-1:0] wr_data,
   input  logic         rd_en,
   input  logic [1:0]   rd_addr,
   output logic [W-1:0] rd_data,
   output logic [1:0]   irq_ch,
   output logic         ovf_flag,
   output logic [W-1:0] count
);
   localparam int NCH = 2;

   if (W < CTL_BITS) begin : g_bad_width
      $error("cc_timer: W must hold the control word");
   end

   tmr_mode_e        mode_q;
   logic [1:0]       edge_q;
   logic [NCH-1:0]   cap_q;
   logic             src_q;
   logic             ctrl_wr;
   logic             evt_hit, cap_hit;
   logic             cnt_en, step, wrap_pend, run, ovf_clr, pin_clr;
   logic [NCH-1:0]   ch_wr;
   logic [W-1:0]     ch_val [NCH];
   logic [W-1:0]     ctrl_rd;

   assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
   assign run     = (mode_q != MODE_STOP);
   assign ovf_clr = ctrl_wr && !wr_data[CTL_OVF];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MODE_STOP;
         edge_q <= 2'b00;
         cap_q  <= '0;
         src_q  <= 1'b0;
      end else if (ctrl_wr) begin
         mode_q <= tmr_mode_e'(wr_data[1:0]);
         cap_q  <= wr_data[CTL_CAP0 +: NCH];
         src_q  <= wr_data[CTL_SRC];
         if (mode_q == MODE_STOP)
            edge_q <= wr_data[CTL_EDGE +: 2];
      end
   end

   cc_sync_edge #(.STAGES(SYNC_STAGES)) u_evt_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(evt_pin), .sel_i(edge_q), .hit_o(evt_hit)
   );

   cc_sync_edge #(.STAGES(SYNC_STAGES)) u_cap_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(cap_pin), .sel_i(2'b00), .hit_o(cap_hit)
   );

   assign cnt_en  = src_q ? evt_hit : tick;
   assign pin_clr = evt_hit;

   cc_count_core #(.W(W)) u_core (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_q), .cnt_en_i(cnt_en),
      .pin_clr_i(pin_clr), .cmp0_i(ch_val[0]), .ovf_clr_i(ovf_clr),
      .step_o(step), .count_o(count), .ovf_o(ovf_flag), .wrap_pend_o(wrap_pend)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign ch_wr[c] = wr_en && (wr_addr == 2'(c));
      cc_ccr_chan #(.W(W)) u_chan (
         .clk(clk), .rst_n(rst_n), .run_i(run), .cap_mode_i(cap_q[c]),
         .cap_trig_i(cap_hit), .step_i(step), .count_i(count),
         .wr_i(ch_wr[c]), .wr_data_i(wr_data), .val_o(ch_val[c]), .irq_o(irq_ch[c])
      );
   end

   always_comb begin
      ctrl_rd                  = '0;
      ctrl_rd[1:0]             = mode_q;
      ctrl_rd[CTL_EDGE +: 2]   = edge_q;
      ctrl_rd[CTL_CAP0 +: NCH] = cap_q;
      ctrl_rd[CTL_SRC]         = src_q;
      ctrl_rd[CTL_OVF]         = ovf_flag;
   end

   always_comb begin
      rd_data = '0;
      if (rd_en) begin
         case (rd_addr)
            ADDR_CH0:  rd_data = ch_val[0];
            ADDR_CH1:  rd_data = ch_val[1];
            ADDR_CTRL: rd_data = ctrl_rd;
            default:   rd_data = '0;
         endcase
      end
   end
endmodule

// File: rtl/cc_timer_chk.sv
module cc_timer_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic [1:0]   mode,
   input logic         step,
   input logic [W-1:0] count,
   input logic [W-1:0] cmp0,
   input logic         ovf,
   input logic         wrap_pend,
   input logic [1:0]   irq,
   input logic         cap_mode0,
   input logic         wr0
);
   assert_hold_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00) |=> (count == '0));

   assert_quiet_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00) |=> (irq == 2'b00));

   assert_wrap_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && count == {W{1'b1}}) |=> ovf);

   assert_clear_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && wrap_pend) |=> ovf);

   assert_step_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !(mode == 2'b10 && count == cmp0)) |=> (count == W'($past(count) + 1)));

   assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (step && mode == 2'b10 && count == cmp0) |=> (count == '0));

   assert_cmp_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_mode0 && !wr0) |=> $stable(cmp0));
endmodule

bind cc_timer cc_timer_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode(mode_q), .step(step), .count(count),
   .cmp0(ch_val[0]), .ovf(ovf_flag), .wrap_pend(wrap_pend), .irq(irq_ch),
   .cap_mode0(cap_q[0]), .wr0(ch_wr[0])
);

// File: tb/cc_timer_tb.sv
module cc_timer_tb;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick = 1'b0, evt_pin = 1'b0, cap_pin = 1'b0;
   logic         wr_en = 1'b0, rd_en = 1'b0;
   logic [1:0]   wr_addr = '0, rd_addr = '0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] rd_data, count;
   logic [1:0]   irq_ch;
   logic         ovf_flag;

   int checks = 0, failures = 0;
   int n_irq0 = 0, n_irq1 = 0;

   always #10 clk = ~clk;

   cc_timer #(.W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .evt_pin(evt_pin), .cap_pin(cap_pin),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en),
      .rd_addr(rd_addr), .rd_data(rd_data), .irq_ch(irq_ch), .ovf_flag(ovf_flag),
      .count(count)
   );

   always @(negedge clk) begin
      if (irq_ch[0]) n_irq0++;
      if (irq_ch[1]) n_irq1++;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      n_irq0 = 0;
      n_irq1 = 0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
      rd_en = 1'b1; rd_addr = a;
      #1 d = rd_data;
      rd_en = 1'b0;
   endtask

   task automatic ticks(input int n);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
   endtask

   task automatic set_evt(input logic v);
      evt_pin = v;
      repeat (6) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [W-1:0] d;
      do_reset();
      chk("R13 count", count, 0);
      chk("R13 ovf", ovf_flag, 0);
      rd(2'd2, d); chk("R13 ctrl", d, 0);
      rd(2'd0, d); chk("R13 ch0", d, 0);
      rd(2'd1, d); chk("R13 ch1", d, 0);
      rd_en = 1'b0; rd_addr = 2'd2; #1 chk("R13 rd_en low", rd_data, 0);
      ticks(2);
      chk("R13 irq", n_irq0 + n_irq1, 0);
   endtask

   task automatic t_start_stop();
      logic [W-1:0] d;
      ticks(5);  chk("R2 stopped count", count, 0);
      wr(2'd2, 16'h0001);
      ticks(5);  chk("R1 running count", count, 5);
      wr(2'd2, 16'h0000);
      @(negedge clk); chk("R1 stop clears", count, 0);
      ticks(3);  chk("R1 stop holds", count, 0);
      wr(2'd2, 16'h0010);
      n_irq0 = 0;
      cap_pin = 1'b1; repeat (6) @(negedge clk);
      cap_pin = 1'b0; repeat (4) @(negedge clk);
      rd(2'd0, d); chk("R2 no capture stopped", d, 0);
      chk("R2 no irq stopped", n_irq0, 0);
   endtask

   task automatic t_match_clear();
      do_reset();
      wr(2'd0, 16'd4);
      wr(2'd2, 16'h0002);
      ticks(5);
      chk("R6 reload", count, 0);
      chk("R6 irq0", n_irq0, 1);
      chk("R6 no ovf", ovf_flag, 0);
      ticks(2);
      chk("R6 restart", count, 2);
   endtask

   task automatic t_capture();
      logic [W-1:0] d;
      do_reset();
      wr(2'd1, 16'h0100);
      wr(2'd2, 16'h0011);
      ticks(16);
      chk("R8 pre count", count, 16'h0010);
      n_irq0 = 0; n_irq1 = 0;
      cap_pin = 1'b1;
      repeat (2) @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'hABCD; rd_en = 1'b1; rd_addr = 2'd0;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      repeat (3) @(negedge clk);
      cap_pin = 1'b0; repeat (4) @(negedge clk);
      rd(2'd0, d); chk("R8 capture wins", d, 16'h0010);
      chk("R8 capture irq", n_irq0, 1);
      rd(2'd1, d); chk("R9 compare ignores capture", d, 16'h0100);
      chk("R9 no irq1", n_irq1, 0);
   endtask

   task automatic t_edge_sel();
      logic [W-1:0] d;
      wr(2'd2, 16'h0015);
      rd(2'd2, d); chk("R10 running edge write ignored", d[3:2], 2'b00);
      wr(2'd2, 16'h0010);
      wr(2'd2, 16'h0014);
      rd(2'd2, d); chk("R10 stopped edge write taken", d[3:2], 2'b01);
   endtask

   task automatic t_pin_clear();
      do_reset();
      wr(2'd2, 16'h0003);
      ticks(7);      chk("R11 pre", count, 7);
      set_evt(1'b1); chk("R11 rising clears", count, 0);
      ticks(3);
      set_evt(1'b0); chk("R11 falling ignored", count, 3);
      wr(2'd2, 16'h0000);
      wr(2'd2, 16'h0007);
      ticks(4);
      set_evt(1'b1); chk("R11 rising ignored", count, 4);
      set_evt(1'b0); chk("R11 falling clears", count, 0);
   endtask

   task automatic t_evt_src();
      do_reset();
      wr(2'd2, 16'h0049);
      ticks(5);      chk("R12 tick ignored", count, 0);
      set_evt(1'b1);
      set_evt(1'b0);
      set_evt(1'b1); chk("R12 edges counted", count, 3);
      set_evt(1'b0);
   endtask

   task automatic t_free_wrap();
      do_reset();
      wr(2'd1, 16'h0000);
      wr(2'd2, 16'h0001);
      ticks(10);
      chk("R5 zero compare at start", n_irq1, 1);
      wr(2'd0, 16'd3);
      n_irq0 = 0; n_irq1 = 0;
      ticks(65525);
      chk("R7 at top", count, 16'hFFFF);
      chk("R7 no early match", n_irq0, 0);
      chk("R3 no ovf before wrap", ovf_flag, 0);
      ticks(1);
      chk("R3 wrap count", count, 0);
      chk("R3 ovf set", ovf_flag, 1);
      wr(2'd2, 16'h0001);
      chk("R4 clear in window ignored", ovf_flag, 1);
      ticks(1);
      chk("R5 zero compare after wrap", n_irq1, 1);
      wr(2'd2, 16'h0101);
      chk("R4 write one keeps flag", ovf_flag, 1);
      wr(2'd2, 16'h0001);
      chk("R4 clear after window", ovf_flag, 0);
      ticks(3);
      chk("R7 match next pass", n_irq0, 1);
   endtask

   task automatic t_mclr_wrap();
      do_reset();
      wr(2'd0, 16'hFFFF);
      wr(2'd2, 16'h0002);
      ticks(65535);
      chk("R3 mclr top", count, 16'hFFFF);
      chk("R3 mclr no ovf yet", ovf_flag, 0);
      ticks(1);
      chk("R3 mclr wrap", count, 0);
      chk("R3 mclr ovf", ovf_flag, 1);
      chk("R6 mclr irq0", n_irq0, 1);
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset();
      t_start_stop();
      t_match_clear();
      t_capture();
      t_edge_sel();
      t_pin_clear();
      t_evt_src();
      t_free_wrap();
      t_mclr_wrap();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule